// File: doc/BRIEF.md
# Channel-Scanning Serial Converter Host

This block drives an external eight-input, 12-bit serial converter from the system clock. It makes the chip select and a free-standing serial clock, shifts a command word to the converter that names the input for the next conversion, and collects the 16 bits that come back. The leading zeros are stripped. Each 12-bit result goes out on a valid/ready stream, tagged with the input it was actually taken from.

The converter always answers one conversion late: the bits read during a conversion belong to the input named in the command of the conversion before. The host keeps that one-deep tag pipeline itself. When a scan starts from idle it runs one throw-away conversion that only sets the first input, and it does not emit that result.

A channel mask picks the inputs. They are visited in ascending order and the order wraps. In continuous mode the chip select stays low from one conversion to the next. In burst mode the chip select goes high after every conversion. Dropping the run input ends the scan after the conversion in flight. If the consumer holds ready low, the host waits at the next conversion boundary and no result is lost.

Top module: `adc_scan_host`

## Requirements
- R1: Every low phase of `sclk` lasts exactly HALF_DIV system clocks. High phases last HALF_DIV clocks, except while the host waits for the consumer or is idle.
- R2: After reset and whenever `csN` is high, `sclk` is high and `resValid` is low until a result exists.
- R3: When `csN` falls, `sclk` is high in that cycle and in the next one, so the first rising edge comes at least HALF_DIV clocks later.
- R4: The 16-bit command word goes out MSB first. Its bits 13:11 carry the requested input (bits 5:3 of the first byte), and all other bits are zero. `mosi` changes only at falling `sclk` edges, so it is steady while `sclk` is high.
- R5: `miso` is sampled at rising `sclk` edges. The result is the last 12 of the 16 bits of a conversion, MSB first, and the first 4 bits are dropped.
- R6: Every low period of `csN` holds a whole multiple of 16 rising `sclk` edges. A stop takes effect only after the conversion in flight has finished.
- R7: `resChan` equals the input named in the command of the conversion before the one that produced `resData`.
- R8: The first conversion after each start from idle is a dummy, and its result never appears on the output.
- R9: Requests go through the set bits of `chanMask` in ascending order and wrap from 7 to 0. The first real request of a scan is the lowest set bit.
- R10: With `chanMask` all zero, `csN` stays high even while `scanEn` is high.
- R11: In continuous mode (`burstMode` = 0) `csN` stays low across conversions. In burst mode every `csN` low period holds exactly 16 rising edges.
- R12: While `resValid` is high and `resReady` is low, `resValid`, `resData` and `resChan` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| scanEn | input | 1 | Run request; scanning stops at a conversion boundary when low |
| burstMode | input | 1 | 1: chip select released after each conversion; 0: held low |
| chanMask | input | 8 | One bit per converter input to include in the scan |
| csN | output | 1 | Converter chip select, active low |
| sclk | output | 1 | Serial clock to the converter, idle high |
| mosi | output | 1 | Command bits to the converter |
| miso | input | 1 | Conversion bits from the converter |
| resValid | output | 1 | Result available |
| resReady | input | 1 | Consumer accepts the result |
| resData | output | 12 | Conversion result, straight binary |
| resChan | output | 3 | Input the result was taken from |

## Verification
The properties assume that `miso` is driven only as a function of the block's own `sclk` and `csN` edges. They also assume that `chanMask` and `burstMode` change only while the block is idle, so the order and frame-length rules have a fixed reference. The stimulus keeps to this: every mask and mode change waits until `csN` has been high for a while and the result stream has drained. `scanEn` and `resReady` are the only inputs that move while a scan runs, and the bench changes them half a clock away from the sampling edge.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  // converter word and field geometry
  localparam int WORD_W   = 16;
  localparam int RES_W    = 12;
  localparam int CHAN_W   = 3;
  localparam int NCHAN    = 1 << CHAN_W;
  localparam int CHAN_LSB = 11;   // word bit 11 = first-byte bit 3
  localparam int BIT_W    = $clog2(WORD_W);

  typedef struct packed {
    logic loadCmd;    // start of conversion: pick channel, load command
    logic firstConv;  // with loadCmd: this conversion is the dummy
    logic shiftTx;    // falling edge inside a conversion
    logic sampleRx;   // rising edge: capture miso
    logic finish;     // all 16 bits captured
  } strobe_t;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_LOW,
    PH_HIGH,
    PH_GAP
  } phase_t;
endpackage

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
  import adc_scan_pkg::*;
#(
  parameter int HALF_DIV = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    scanEn,
  input  logic    burstMode,
  input  logic    maskAny,
  input  logic    resValid,
  input  logic    resReady,
  output logic    csN,
  output logic    sclk,
  output strobe_t stb
);
  localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_DIV - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(WORD_W - 1);

  phase_t           phase;
  logic [CNT_W-1:0] cnt;
  logic [BIT_W-1:0] bitIdx;
  logic             csReg;
  logic             sclkReg;
  logic             firstPend;

  logic halfEnd, canRun, resFree, lastBit;

  assign halfEnd = (cnt == CNT_LAST);
  assign canRun  = scanEn && maskAny;
  assign resFree = !resValid || resReady;
  assign lastBit = (bitIdx == BIT_LAST);
  assign csN     = csReg;
  assign sclk    = sclkReg;

  always_comb begin
    stb = '0;
    stb.finish = (phase == PH_HIGH) && lastBit && (cnt == '0);
    case (phase)
      PH_SETUP: begin
        if (halfEnd && canRun) begin
          stb.loadCmd   = 1'b1;
          stb.firstConv = firstPend;
        end
      end
      PH_LOW: begin
        if (halfEnd) stb.sampleRx = 1'b1;
      end
      PH_HIGH: begin
        if (halfEnd) begin
          if (!lastBit) begin
            stb.shiftTx = 1'b1;
          end else if (resFree && canRun && !burstMode) begin
            stb.loadCmd = 1'b1;
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      bitIdx    <= '0;
      csReg     <= 1'b1;
      sclkReg   <= 1'b1;
      firstPend <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: begin
          cnt <= '0;
          if (canRun) begin
            phase     <= PH_SETUP;
            csReg     <= 1'b0;
            firstPend <= 1'b1;
          end
        end
        PH_SETUP: begin
          if (!halfEnd) begin
            cnt <= cnt + 1'b1;
          end else begin
            cnt <= '0;
            if (canRun) begin
              phase     <= PH_LOW;
              sclkReg   <= 1'b0;
              bitIdx    <= '0;
              firstPend <= 1'b0;
            end else begin
              phase <= PH_IDLE;
              csReg <= 1'b1;
            end
          end
        end
        PH_LOW: begin
          if (!halfEnd) begin
            cnt <= cnt + 1'b1;
          end else begin
            cnt     <= '0;
            phase   <= PH_HIGH;
            sclkReg <= 1'b1;
          end
        end
        PH_HIGH: begin
          if (!halfEnd) begin
            cnt <= cnt + 1'b1;
          end else if (!lastBit) begin
            cnt     <= '0;
            phase   <= PH_LOW;
            sclkReg <= 1'b0;
            bitIdx  <= bitIdx + 1'b1;
          end else if (resFree) begin
            cnt <= '0;
            if (canRun && !burstMode) begin
              phase   <= PH_LOW;
              sclkReg <= 1'b0;
              bitIdx  <= '0;
            end else begin
              phase <= PH_GAP;
              csReg <= 1'b1;
            end
          end
        end
        PH_GAP: begin
          if (!halfEnd) begin
            cnt <= cnt + 1'b1;
          end else begin
            cnt <= '0;
            if (canRun) begin
              phase <= PH_SETUP;
              csReg <= 1'b0;
            end else begin
              phase <= PH_IDLE;
            end
          end
        end
        default: begin
          phase   <= PH_IDLE;
          csReg   <= 1'b1;
          sclkReg <= 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/adc_scan_dp.sv
module adc_scan_dp
  import adc_scan_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [NCHAN-1:0]  chanMask,
  input  logic              miso,
  input  logic              resReady,
  output logic              mosi,
  output logic              resValid,
  output logic [RES_W-1:0]  resData,
  output logic [CHAN_W-1:0] resChan
);
  logic [WORD_W-1:0] txWord;
  logic [WORD_W-1:0] txNext;
  logic [RES_W-1:0]  rxWord;
  logic [CHAN_W-1:0] reqCh;
  logic [CHAN_W-1:0] pendCh;
  logic [CHAN_W-1:0] baseCh;
  logic [CHAN_W-1:0] pickCh;
  logic              convDummy;

  assign baseCh = stb.firstConv ? CHAN_W'(NCHAN - 1) : reqCh;

  // next set mask bit above baseCh, wrapping
  always_comb begin
    logic             found;
    logic [CHAN_W-1:0] idx;
    found  = 1'b0;
    pickCh = baseCh;
    for (int k = 1; k <= NCHAN; k++) begin
      idx = baseCh + CHAN_W'(k);
      if (!found && chanMask[idx]) begin
        pickCh = idx;
        found  = 1'b1;
      end
    end
  end

  always_comb begin
    txNext = '0;
    txNext[CHAN_LSB +: CHAN_W] = pickCh;
  end

  assign mosi = txWord[WORD_W-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txWord    <= '0;
      rxWord    <= '0;
      reqCh     <= '0;
      pendCh    <= '0;
      convDummy <= 1'b1;
    end else begin
      if (stb.loadCmd) begin
        txWord    <= txNext;
        reqCh     <= pickCh;
        pendCh    <= reqCh;
        convDummy <= stb.firstConv;
      end else if (stb.shiftTx) begin
        txWord <= {txWord[WORD_W-2:0], 1'b0};
      end
      if (stb.sampleRx) rxWord <= {rxWord[RES_W-2:0], miso};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid <= 1'b0;
      resData  <= '0;
      resChan  <= '0;
    end else if (stb.finish && !convDummy) begin
      resValid <= 1'b1;
      resData  <= rxWord;
      resChan  <= pendCh;
    end else if (resValid && resReady) begin
      resValid <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_scan_host.sv
module adc_scan_host
  import adc_scan_pkg::*;
#(
  parameter int HALF_DIV = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        scanEn,
  input  logic        burstMode,
  input  logic [7:0]  chanMask,
  output logic        csN,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic        resValid,
  input  logic        resReady,
  output logic [11:0] resData,
  output logic [2:0]  resChan
);
  strobe_t stb;

  adc_scan_ctrl #(.HALF_DIV(HALF_DIV)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .scanEn   (scanEn),
    .burstMode(burstMode),
    .maskAny  (|chanMask),
    .resValid (resValid),
    .resReady (resReady),
    .csN      (csN),
    .sclk     (sclk),
    .stb      (stb)
  );

  adc_scan_dp dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .chanMask(chanMask),
    .miso    (miso),
    .resReady(resReady),
    .mosi    (mosi),
    .resValid(resValid),
    .resData (resData),
    .resChan (resChan)
  );
endmodule

// File: rtl/adc_scan_chk.sv
module adc_scan_chk #(
  parameter int HALF_DIV = 4
) (
  input logic        clk,
  input logic        rstN,
  input logic        csN,
  input logic        sclk,
  input logic        mosi,
  input logic        resValid,
  input logic        resReady,
  input logic [11:0] resData,
  input logic [2:0]  resChan
);
  localparam int LEN_W = $clog2(HALF_DIV + 1) + 1;
  localparam int MOD_W = 4;

  logic [LEN_W-1:0] lowLen;
  logic [MOD_W-1:0] riseMod;
  logic             sclkQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowLen  <= '0;
      riseMod <= '0;
      sclkQ   <= 1'b1;
    end else begin
      sclkQ  <= sclk;
      lowLen <= sclk ? '0 : lowLen + 1'b1;
      if (csN) riseMod <= '0;
      else if (sclk && !sclkQ) riseMod <= riseMod + 1'b1;
    end
  end

  // R1
  low_phase_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sclk && !sclkQ) |-> (lowLen == LEN_W'(HALF_DIV)));

  // R2
  idle_clock_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> sclk);

  // R3
  cs_setup_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |-> sclk ##1 (sclk && !csN));

  // R4
  din_steady_chk: assert property (@(posedge clk) disable iff (!rstN)
    sclk |-> $stable(mosi));

  // R6
  frame_whole_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |-> (riseMod == '0));

  // R12
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !resReady) |=> (resValid && $stable(resData) && $stable(resChan)));
endmodule

bind adc_scan_host adc_scan_chk #(.HALF_DIV(HALF_DIV)) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .csN     (csN),
  .sclk    (sclk),
  .mosi    (mosi),
  .resValid(resValid),
  .resReady(resReady),
  .resData (resData),
  .resChan (resChan)
);

// File: tb/adc_scan_host_tb_top.sv
module adc_scan_host_tb_top;
  localparam int HALF = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rstN = 1'b0;
  logic        scanEn = 1'b0;
  logic        burstMode = 1'b0;
  logic [7:0]  chanMask = 8'h00;
  logic        miso = 1'b0;
  logic        resReady = 1'b1;
  logic        csN, sclk, mosi, resValid;
  logic [11:0] resData;
  logic [2:0]  resChan;

  adc_scan_host #(.HALF_DIV(HALF)) dut_i (
    .clk(clk), .rstN(rstN), .scanEn(scanEn), .burstMode(burstMode),
    .chanMask(chanMask), .csN(csN), .sclk(sclk), .mosi(mosi), .miso(miso),
    .resValid(resValid), .resReady(resReady), .resData(resData), .resChan(resChan)
  );

  int errs = 0;
  int checks = 0;
  int cyc = 0;
  int readyMode = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [2:0] nextEn(input logic [2:0] b, input logic [7:0] m);
    logic [2:0] r;
    logic [2:0] i;
    r = b;
    for (int k = 1; k <= 8; k++) begin
      i = 3'(int'(b) + k);
      if (m[i]) begin
        r = i;
        break;
      end
    end
    return r;
  endfunction

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  // consumer ready pattern, driven away from the clock edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      resReady = (readyMode == 0) ? 1'b1 : ((cyc % 9) < 2);
    end
  end

  // behavioural converter model and stream reference
  typedef struct packed { logic [2:0] ch; logic [11:0] d; } res_t;
  res_t       expQ[$];
  logic       sclkQ = 1'b1, csQ = 1'b1, mosiQ = 1'b0;
  int         riseCnt = 0, lowLen = 0, convCount = 0, p = 0, rcv = 0;
  logic [2:0] nextCh = 3'd5;
  logic [2:0] curCh = 3'd0;
  logic [11:0] curData = '0;
  logic [7:0] cmdSh = '0;
  bit         curDummy = 1'b0, dummyArm = 1'b0, orderInit = 1'b1;
  logic [2:0] lastCh = 3'd7;
  logic       pValid = 1'b0, pReady = 1'b1;
  logic [11:0] pData = '0;
  logic [2:0] pChan = '0;
  res_t       got;

  always @(negedge clk) begin
    if (rstN) begin
      if (csN) check(sclk == 1'b1, "R2", "sclk while deselected", int'(sclk), 1);
      if (sclk && sclkQ) check(mosi == mosiQ, "R4", "mosi moved while sclk high", int'(mosi), int'(mosiQ));
      if (csQ && !csN) riseCnt = 0;
      if (!csN && sclkQ && !sclk) begin
        p = riseCnt % 16;
        if (p == 0) begin
          curCh = nextCh;
          convCount++;
          curData = {curCh, 9'(convCount * 37)};
          curDummy = dummyArm;
          dummyArm = 1'b0;
        end
        miso = (p < 4) ? 1'b0 : curData[15 - p];
      end
      if (!csN && !sclkQ && sclk) begin
        p = riseCnt % 16;
        check(lowLen == HALF, "R1", "low phase length", lowLen, HALF);
        if (p < 8) cmdSh = {cmdSh[6:0], mosi};
        if (p == 7) begin
          check((cmdSh & 8'hC7) == 8'h00, "R4", "unused command bits", int'(cmdSh & 8'hC7), 0);
          nextCh = cmdSh[5:3];
        end
        if (p > 7) check(mosi == 1'b0, "R4", "second command byte", int'(mosi), 0);
        riseCnt++;
        if (p == 15 && !curDummy) expQ.push_back('{ch: curCh, d: curData});
      end
      if (!csQ && csN) begin
        check((riseCnt % 16) == 0, "R6", "rising edges in frame mod 16", riseCnt % 16, 0);
        if (burstMode) check(riseCnt == 16, "R11", "burst frame edges", riseCnt, 16);
        else check(riseCnt >= 32, "R11", "continuous frame holds several conversions", riseCnt, 32);
      end
      if (pValid && !pReady) begin
        check(resValid && resData == pData && resChan == pChan, "R12",
              "held result data", int'(resData), int'(pData));
      end
      if (resValid && resReady) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R8", "unexpected result (dummy leaked)", int'(resChan), -1);
        end else begin
          got = expQ.pop_front();
          check(resChan == got.ch, "R8", "result channel vs converted", int'(resChan), int'(got.ch));
          check(resData == got.d, "R5", "result data", int'(resData), int'(got.d));
        end
        check(resData[11:9] == resChan, "R7", "tag matches converted input", int'(resChan), int'(resData[11:9]));
        check(resChan == nextEn(orderInit ? 3'd7 : lastCh, chanMask), "R9", "scan order",
              int'(resChan), int'(nextEn(orderInit ? 3'd7 : lastCh, chanMask)));
        orderInit = 1'b0;
        lastCh = resChan;
        rcv++;
      end
      if (!sclk) lowLen++; else lowLen = 0;
      sclkQ = sclk; csQ = csN; mosiQ = mosi;
      pValid = resValid; pReady = resReady; pData = resData; pChan = resChan;
    end
  end

  task automatic runScan(input logic [7:0] m, input logic burst, input int n, input int rmode);
    int target;
    @(posedge clk); #2;
    chanMask = m;
    burstMode = burst;
    readyMode = rmode;
    dummyArm = 1'b1;
    orderInit = 1'b1;
    target = rcv + n;
    scanEn = 1'b1;
    while (rcv < target) @(negedge clk);
    @(posedge clk); #2;
    scanEn = 1'b0;
    readyMode = 0;
    while (!csN) @(negedge clk);
    repeat (8 * HALF + 16) @(negedge clk);
    check(expQ.size() == 0, "R6", "results pending after stop", expQ.size(), 0);
    check(resValid == 1'b0 && csN == 1'b1, "R2", "idle after stop", int'(resValid), 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    check(csN == 1'b1, "R2", "csN in reset", int'(csN), 1);
    check(sclk == 1'b1, "R2", "sclk in reset", int'(sclk), 1);
    check(resValid == 1'b0, "R2", "resValid in reset", int'(resValid), 0);
    @(posedge clk); #2;
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check(csN == 1'b1 && sclk == 1'b1, "R2", "idle after reset", int'(csN), 1);

    // R10: empty mask never opens a frame
    @(posedge clk); #2;
    chanMask = 8'h00;
    scanEn = 1'b1;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      check(csN == 1'b1, "R10", "csN with empty mask", int'(csN), 1);
    end
    @(posedge clk); #2;
    scanEn = 1'b0;

    runScan(8'hA5, 1'b0, 12, 0);   // continuous, sparse mask (R9, R11)
    runScan(8'h31, 1'b1, 8, 0);    // burst (R11)
    runScan(8'hFF, 1'b0, 20, 1);   // continuous with back-pressure (R12)
    runScan(8'h80, 1'b0, 5, 0);    // single top input, wrap (R9)
    runScan(8'h42, 1'b1, 6, 1);    // burst with back-pressure
    runScan(8'h0C, 1'b0, 7, 1);    // restart: dummy again (R8)

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule